// File: doc/BRIEF.md
# Dual-Channel Chip-Selected DAC Word Latches

This block is the digital front end of a two-channel converter. A 12-bit word arrives on a parallel bus in a single write cycle. It is steered into the holding register of channel A, of channel B, or of both. One active-low write strobe is shared by both channels, and each channel has its own active-low select. The two register values drive the converter cores directly.

The control pins and the data bus are asynchronous to the system clock. Each one passes through a two-stage synchronizer before any logic uses it. The transparent-latch behaviour is modelled as a register that reloads on every clock cycle in which its select and the strobe are both low. When the strobe or the select returns high, loading stops, so the register keeps the last word it saw. A registered flag pair reports which channels took a word in each cycle.

Top module: `dual_dac_latch`

## Requirements
- R1: While the synchronous active-high reset is asserted, both channel registers and both flags go to zero on the next clock edge.
- R2: While `sel_a_n` and `wr_n` are both low, `chan_a` follows `din`.
- R3: While `sel_b_n` and `wr_n` are both low, `chan_b` follows `din`.
- R4: While both selects and `wr_n` are low, one word is loaded into both channels, so `chan_a` equals `chan_b`.
- R5: While `wr_n` is high, neither register changes, whatever the selects and the data do.
- R6: While both selects are high, neither register changes, even with `wr_n` low.
- R7: When `wr_n` rises, each register that was loading keeps the word present on the bus just before the rise. Data that changes in the same cycle as the rise, or afterwards, is ignored.
- R8: When a select rises while `wr_n` stays low, that channel keeps its last loaded word.
- R9: `wr_flags` bit 0 is high in each cycle in which channel A was loaded, and bit 1 is high in each cycle in which channel B was loaded. Both bits are registered.
- R10: An input change reaches the outputs exactly SYNC_STAGES+1 clock edges later (3 with the default setting), and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Shared write strobe, active low, asynchronous |
| sel_a_n | input | 1 | Channel A select, active low, asynchronous |
| sel_b_n | input | 1 | Channel B select, active low, asynchronous |
| din | input | DATA_W | Parallel data word |
| chan_a | output | DATA_W | Channel A holding register |
| chan_b | output | DATA_W | Channel B holding register |
| wr_flags | output | 2 | Per-channel load flags: bit 0 is A, bit 1 is B |

## Verification
The hardest case to reach is the strobe or a select rising in the same cycle as the data changes. In that case the register must keep the earlier word and not pick up the new one. The stimulus reaches this by following every load with a release step. That step raises the strobe, or both selects, on the same clock edge that places a different word on the bus. Every combination of strobe and select levels is swept across several data patterns. A separate step counts the exact number of clock edges between an input change and the change at the outputs.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

    localparam int NUM_CHAN = 2;

    // Synchronized control pins, still active low
    typedef struct packed {
        logic       wr_n;
        logic [NUM_CHAN-1:0] sel_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{wr_n: 1'b1, sel_n: '1};

    function automatic logic chan_load(ctrl_t c, int ch);
        return !c.wr_n && !c.sel_n[ch];
    endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                st_d.chain[i] = RST_VAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.chain[STAGES-1];

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] value,
    output logic              wrote
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              wrote;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wrote = load;
        if (load) begin
            st_d.value = word;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign value = st_q.value;
    assign wrote = st_q.wrote;

endmodule

// File: rtl/dual_dac_latch.sv
module dual_dac_latch
    import dac_latch_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] chan_a,
    output logic [DATA_W-1:0] chan_b,
    output logic [1:0]        wr_flags
);

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_raw, ctrl_s;
    logic [DATA_W-1:0] din_s;
    logic [NUM_CHAN-1:0][DATA_W-1:0] chan_val;
    logic [NUM_CHAN-1:0]             chan_wrote;

    always_comb begin
        ctrl_raw.wr_n     = wr_n;
        ctrl_raw.sel_n[0] = sel_a_n;
        ctrl_raw.sel_n[1] = sel_b_n;
    end

    dac_sync #(
        .W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)
    ) u_sync_ctrl (
        .clk(clk), .rst(rst), .d(ctrl_raw), .q(ctrl_s)
    );

    dac_sync #(
        .W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)
    ) u_sync_data (
        .clk(clk), .rst(rst), .d(din), .q(din_s)
    );

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        dac_chan #(.DATA_W(DATA_W)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .load (chan_load(ctrl_s, ch)),
            .word (din_s),
            .value(chan_val[ch]),
            .wrote(chan_wrote[ch])
        );
    end

    assign chan_a   = chan_val[0];
    assign chan_b   = chan_val[1];
    assign wr_flags = chan_wrote;

endmodule

// File: rtl/dual_dac_latch_chk.sv
module dual_dac_latch_chk #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_n,
    input logic              sel_a_n,
    input logic              sel_b_n,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] chan_a,
    input logic [DATA_W-1:0] chan_b,
    input logic [1:0]        wr_flags
);

    localparam int PW = DATA_W + 3;

    // Delayed copy of the pins as the port-level timing model
    logic [SYNC_STAGES-1:0][PW-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= {3'b111, {DATA_W{1'b0}}};
        end else begin
            pipe[0] <= {wr_n, sel_b_n, sel_a_n, din};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    logic              d_wr_n, d_sb_n, d_sa_n;
    logic [DATA_W-1:0] d_din;
    assign {d_wr_n, d_sb_n, d_sa_n, d_din} = pipe[SYNC_STAGES-1];

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (chan_a == '0 && chan_b == '0 && wr_flags == 2'b00));

    a_r2_chan_a_follows: assert property (@(posedge clk) disable iff (rst)
        (!d_wr_n && !d_sa_n) |=> chan_a == $past(d_din));

    a_r3_chan_b_follows: assert property (@(posedge clk) disable iff (rst)
        (!d_wr_n && !d_sb_n) |=> chan_b == $past(d_din));

    a_r4_both_equal: assert property (@(posedge clk) disable iff (rst)
        (!d_wr_n && !d_sa_n && !d_sb_n) |=> chan_a == chan_b);

    a_r5_strobe_high_holds: assert property (@(posedge clk) disable iff (rst)
        d_wr_n |=> ($stable(chan_a) && $stable(chan_b)));

    a_r6_no_select_holds: assert property (@(posedge clk) disable iff (rst)
        (d_sa_n && d_sb_n) |=> ($stable(chan_a) && $stable(chan_b)));

    a_r9_flags_match: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wr_flags == $past({!d_wr_n && !d_sb_n, !d_wr_n && !d_sa_n}));

endmodule

bind dual_dac_latch dual_dac_latch_chk #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk(clk), .rst(rst), .wr_n(wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .din(din), .chan_a(chan_a), .chan_b(chan_b), .wr_flags(wr_flags)
);

// File: tb/dual_dac_latch_test.sv
module dual_dac_latch_test;

    localparam int W = 12;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_n = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] chan_a, chan_b;
    logic [1:0]   wr_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [W-1:0] exp_a = '0, exp_b = '0;

    always #2.5 clk = ~clk;

    dual_dac_latch uut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .din(din), .chan_a(chan_a), .chan_b(chan_b), .wr_flags(wr_flags)
    );

    task automatic check(string req, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Drive inputs, wait until settled, compare with the model
    task automatic apply(logic w, logic sa, logic sb, logic [W-1:0] d, string req);
        @(negedge clk);
        wr_n = w; sel_a_n = sa; sel_b_n = sb; din = d;
        if (!w && !sa) exp_a = d;
        if (!w && !sb) exp_b = d;
        repeat (LAT + 1) @(negedge clk);
        check(req, "chan_a", int'(chan_a), int'(exp_a));
        check(req, "chan_b", int'(chan_b), int'(exp_b));
        check("R9", "wr_flags", int'(wr_flags), int'({!w && !sb, !w && !sa}));
    endtask

    function automatic string tag(logic w, logic sa, logic sb);
        if (w) return "R5";
        if (sa && sb) return "R6";
        if (!sa && !sb) return "R4";
        if (!sa) return "R2";
        return "R3";
    endfunction

    initial begin
        logic [W-1:0] pat [6];
        pat[0] = 12'h000; pat[1] = 12'hFFF; pat[2] = 12'hA5A;
        pat[3] = 12'h5A5; pat[4] = 12'h801; pat[5] = 12'h3C7;

        repeat (3) @(negedge clk);
        check("R1", "chan_a", int'(chan_a), 0);
        check("R1", "chan_b", int'(chan_b), 0);
        check("R1", "wr_flags", int'(wr_flags), 0);
        rst = 1'b0;

        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic [W-1:0] d;
                d = pat[p] ^ W'(c * 12'h111);
                apply(c[2], c[1], c[0], d, tag(c[2], c[1], c[0]));
                if (!c[2] && c[1:0] != 2'b11) begin
                    // strobe rises with new data on the bus in the same cycle
                    apply(1'b1, c[1], c[0], ~d, "R7");
                    apply(1'b0, c[1], c[0], d ^ 12'h0F0, tag(1'b0, c[1], c[0]));
                    // selects rise while strobe remains low
                    apply(1'b0, 1'b1, 1'b1, ~d, "R8");
                end
            end
        end

        // R8: channel A select released while B keeps loading
        apply(1'b0, 1'b0, 1'b0, 12'h123, "R4");
        apply(1'b0, 1'b1, 1'b0, 12'h456, "R8");

        // R10: exact latency of one write
        apply(1'b1, 1'b1, 1'b1, 12'h000, "R5");
        @(negedge clk);
        wr_n = 1'b0; sel_a_n = 1'b0; din = 12'hBEE;
        repeat (LAT - 1) @(negedge clk);
        check("R10", "chan_a early", int'(chan_a), int'(exp_a));
        check("R10", "flags early", int'(wr_flags), 0);
        @(negedge clk);
        check("R10", "chan_a on time", int'(chan_a), 12'hBEE);
        check("R10", "flags on time", int'(wr_flags), 1);
        exp_a = 12'hBEE;
        apply(1'b1, 1'b1, 1'b1, 12'h000, "R7");

        // R1: reset during activity
        @(negedge clk);
        wr_n = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0; din = 12'h777;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "chan_a mid reset", int'(chan_a), 0);
        check("R1", "chan_b mid reset", int'(chan_b), 0);
        check("R1", "flags mid reset", int'(wr_flags), 0);
        wr_n = 1'b1; sel_a_n = 1'b1; sel_b_n = 1'b1;
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule